// File: doc/BRIEF.md
# Receive Character Queue with Threshold Interrupt

This block sits between a serial deserializer and a host. Each time the deserializer finishes a character it raises a one-cycle valid strobe along with the character bits. The block clears every bit above the configured character length and then stores the result. The host takes characters through a single read port.

In queue mode, characters collect in a 64-entry first-in first-out store. A read always returns the oldest entry. A level interrupt is raised while the number of stored characters is at or above a threshold that the host selects. In single-register mode, one holding register keeps only the most recent character. A new arrival replaces the held character, and the interrupt follows whether the register is full.

A sticky overrun flag records any character that was lost. The host clears it with an acknowledge pulse. Changing the mode input discards everything that is stored.

Top module: `rx_char_queue`

## Requirements
- R1: After a synchronous reset the block holds no characters: `empty_o`=1, `irq_o`=0, `overrun_o`=0 and `rd_data_o`=0.
- R2: In queue mode (`fifo_mode_i`=1), each read pulse returns the oldest stored character and removes it from the store.
- R3: A stored character keeps only its low bits, as set by `char_len_i`: code 0 keeps 5 bits, 1 keeps 6, 2 keeps 7 and 3 keeps 8. Every higher bit reads as zero. For example, 0xE5 at length code 0 reads as 0x05.
- R4: In queue mode, `trig_lvl_i` selects the interrupt threshold: code 0 is 1 character, 1 is 8, 2 is 16 and 3 is 32. `irq_o` is 1 exactly while the occupancy is at or above the selected threshold.
- R5: `irq_o` is a level. It falls in the first cycle in which occupancy is below the threshold, and it is 0 whenever the block is empty.
- R6: When 64 characters are stored, an arriving character with no read in the same cycle is discarded. The stored contents are unchanged and `overrun_o` is set.
- R7: `overrun_o` stays set until an `ovr_ack_i` pulse clears it. If a new loss happens in the same cycle as the pulse, the flag stays set.
- R8: A read while the block is empty returns 0 on `rd_data_o` and leaves the store unchanged.
- R9: In queue mode, when an arrival and a read fall in the same cycle and the store is not empty, the oldest character is returned, the new one is appended, and the occupancy is unchanged. This also applies when the store is full.
- R10: In single-register mode (`fifo_mode_i`=0), a read returns the held character and empties the register. An arrival overwrites the register. Overwriting a character that has not been read, with no read in the same cycle, sets `overrun_o`. `irq_o` equals "register full".
- R11: A change of `fifo_mode_i` discards all stored characters at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_vld_i | input | 1 | One-cycle strobe: a received character is present on `char_i` |
| char_i | input | 8 | Received character bits, least significant bit first in position 0 |
| char_len_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| rd_i | input | 1 | Host read pulse; `rd_data_o` is valid in the same cycle |
| fifo_mode_i | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| trig_lvl_i | input | 2 | Interrupt threshold select (1/8/16/32 characters) |
| ovr_ack_i | input | 1 | Clears the overrun flag |
| rd_data_o | output | 8 | Oldest or held character, 0 when empty |
| irq_o | output | 1 | Receive-data interrupt level |
| empty_o | output | 1 | No character stored |
| overrun_o | output | 1 | Sticky lost-character flag |

## Verification
`rd_data_o` is combinational from the stored state, so the bench compares it in the same cycle in which it raises `rd_i`, two time units after the falling edge. The effect of an arrival, a pop, a flush or an acknowledge shows on `empty_o`, `irq_o` and `overrun_o` after exactly one rising edge. The bench samples these three outputs 3 time units after that edge. A scoreboard queue holds the expected characters. It is updated when the stimulus is driven, so every expected value is ready before the edge that produces the matching result.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_8  = 2'd1,
        TRIG_16 = 2'd2,
        TRIG_32 = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        LEN_5 = 2'd0,
        LEN_6 = 2'd1,
        LEN_7 = 2'd2,
        LEN_8 = 2'd3
    } clen_e;

    typedef struct packed {
        logic              vld;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    function automatic logic [CHAR_W-1:0] rjust(logic [CHAR_W-1:0] c, clen_e l);
        logic [CHAR_W-1:0] m;
        case (l)
            LEN_5:   m = 8'h1F;
            LEN_6:   m = 8'h3F;
            LEN_7:   m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return c & m;
    endfunction

    function automatic int unsigned trig_count(trig_e t);
        case (t)
            TRIG_1:  return 1;
            TRIG_8:  return 8;
            TRIG_16: return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  rx_char_t          wr,
    input  logic              pop,
    output logic [CHAR_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              dropped
);

    logic [CHAR_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, empty, push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = wr.vld && (!full || pop_ok);
    assign dropped = wr.vld && full && !pop_ok;
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush && !rst) mem[wr_ptr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr.vld && pop && !empty && !flush) |=> $stable(count)); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !wr.vld && !flush) |=> ($stable(rd_ptr) && count == '0)); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0)); // R11

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_mode,
    input  trig_e         trig,
    input  logic [CW-1:0] count,
    input  logic          hold_full,
    output logic          irq
);

    logic fifo_hit;

    assign fifo_hit = (32'(count) >= trig_count(trig));
    assign irq      = fifo_mode ? fifo_hit : hold_full;

    AST_IRQ_ZERO_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && count == '0) |-> !irq); // R5
    AST_IRQ_FULL_QUEUE: assert property (@(posedge clk) disable iff (rst)
        (fifo_mode && count == CW'(DEPTH)) |-> irq); // R4

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       char_vld_i,
    input  logic [7:0] char_i,
    input  logic [1:0] char_len_i,
    input  logic       rd_i,
    input  logic       fifo_mode_i,
    input  logic [1:0] trig_lvl_i,
    input  logic       ovr_ack_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o,
    output logic       empty_o,
    output logic       overrun_o
);

    rx_char_t          in_c, q_wr;
    logic              mode_q, flush;
    logic [CHAR_W-1:0] q_head;
    logic [CW-1:0]     q_count;
    logic              q_drop;
    rx_char_t          hold_q;
    logic              hold_lost, lost;

    assign in_c.vld  = char_vld_i;
    assign in_c.data = rjust(char_i, clen_e'(char_len_i));
    assign flush     = (fifo_mode_i != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= fifo_mode_i;
        else     mode_q <= fifo_mode_i;
    end

    always_comb begin
        q_wr     = in_c;
        q_wr.vld = in_c.vld && fifo_mode_i;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr      (q_wr),
        .pop     (rd_i && fifo_mode_i),
        .head    (q_head),
        .count   (q_count),
        .dropped (q_drop)
    );

    // Single-register mode holder
    assign hold_lost = !fifo_mode_i && in_c.vld && hold_q.vld && !rd_i;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hold_q <= '0;
        end else if (!fifo_mode_i) begin
            if (in_c.vld)  hold_q <= in_c;
            else if (rd_i) hold_q.vld <= 1'b0;
        end
    end

    assign lost = (fifo_mode_i && q_drop) || hold_lost;

    always_ff @(posedge clk) begin
        if (rst)            overrun_o <= 1'b0;
        else if (lost)      overrun_o <= 1'b1;
        else if (ovr_ack_i) overrun_o <= 1'b0;
    end

    rxq_trigger #(.DEPTH(DEPTH)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode_i),
        .trig      (trig_e'(trig_lvl_i)),
        .count     (q_count),
        .hold_full (hold_q.vld),
        .irq       (irq_o)
    );

    assign empty_o   = fifo_mode_i ? (q_count == '0) : !hold_q.vld;
    assign rd_data_o = fifo_mode_i ? q_head : (hold_q.vld ? hold_q.data : '0);

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !ovr_ack_i) |=> overrun_o); // R7
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> (rd_data_o == '0 && !irq_o)); // R8
    AST_LOSS_FLAG: assert property (@(posedge clk) disable iff (rst)
        lost |=> overrun_o); // R6

endmodule

// File: tb/rx_char_queue_tb.sv
module rx_char_queue_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       char_vld_i, rd_i, fifo_mode_i, ovr_ack_i;
    logic [7:0] char_i;
    logic [1:0] char_len_i, trig_lvl_i;
    logic [7:0] rd_data_o;
    logic       irq_o, empty_o, overrun_o;

    int total = 0, failed = 0;
    logic [7:0] q[$];
    int   pre_sz;
    logic exp_ovr;
    bit   done = 0;

    always #10 clk = ~clk;

    rx_char_queue u_dut (
        .clk(clk), .rst(rst), .char_vld_i(char_vld_i), .char_i(char_i),
        .char_len_i(char_len_i), .rd_i(rd_i), .fifo_mode_i(fifo_mode_i),
        .trig_lvl_i(trig_lvl_i), .ovr_ack_i(ovr_ack_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o), .empty_o(empty_o), .overrun_o(overrun_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int thr(input logic [1:0] t);
        case (t)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    // Monitor: compares read data in the read cycle, popping the scoreboard
    always @(negedge clk) begin
        #2;
        if (!rst && rd_i) begin
            if (pre_sz == 0) check("R8 empty read", rd_data_o, 8'h00);
            else check("R2/R3/R10 read data", rd_data_o, q.pop_front());
        end
    end

    task automatic status(input string req);
        logic e_irq;
        e_irq = fifo_mode_i ? (q.size() >= thr(trig_lvl_i)) : (q.size() > 0);
        check({req, " irq"}, {7'd0, irq_o}, {7'd0, e_irq});
        check({req, " empty"}, {7'd0, empty_o}, {7'd0, q.size() == 0});
        check({req, " overrun"}, {7'd0, overrun_o}, {7'd0, exp_ovr});
    endtask

    // Driver: one cycle of stimulus, scoreboard updated before the edge
    task automatic step(input logic p, input logic [7:0] c, input logic [1:0] l,
                        input logic r, input logic ack, input string req);
        logic [7:0] m;
        logic lost;
        @(negedge clk);
        char_vld_i = p; char_i = c; char_len_i = l; rd_i = r; ovr_ack_i = ack;
        pre_sz = q.size();
        lost = 1'b0;
        m = c & 8'((1 << (5 + l)) - 1);
        if (p) begin
            if (fifo_mode_i) begin
                if (pre_sz < 64 || r) q.push_back(m);
                else lost = 1'b1;
            end else begin
                if (pre_sz > 0 && !r) begin
                    void'(q.pop_front());
                    lost = 1'b1;
                end
                q.push_back(m);
            end
        end
        if (lost) exp_ovr = 1'b1;
        else if (ack) exp_ovr = 1'b0;
        @(posedge clk);
        #3;
        char_vld_i = 0; rd_i = 0; ovr_ack_i = 0;
        status(req);
    endtask

    task automatic set_mode(input logic md);
        @(negedge clk);
        fifo_mode_i = md;
        @(posedge clk);
        #3;
        q.delete();
        status("R11 mode flush");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        rst = 1; char_vld_i = 0; char_i = 0; char_len_i = 3; rd_i = 0;
        fifo_mode_i = 1; trig_lvl_i = 0; ovr_ack_i = 0; exp_ovr = 0; pre_sz = 0;
        repeat (3) @(posedge clk);
        #3 rst = 0;
        #1;
        check("R1 reset empty", {7'd0, empty_o}, 8'd1);
        check("R1 reset irq", {7'd0, irq_o}, 8'd0);
        check("R1 reset overrun", {7'd0, overrun_o}, 8'd0);
        check("R1 reset data", rd_data_o, 8'd0);

        // R3: length codes with junk in upper bits; R2 order
        step(1, 8'hE5, 2'd0, 0, 0, "R3 len5");
        step(1, 8'hFF, 2'd1, 0, 0, "R3 len6");
        step(1, 8'hC3, 2'd2, 0, 0, "R3 len7");
        step(1, 8'hA7, 2'd3, 0, 0, "R3 len8");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R2 drain");
        // R8 empty read, then pointers intact
        step(0, 0, 0, 1, 0, "R8 empty read");
        step(1, 8'h5A, 2'd3, 0, 0, "R8 after");
        step(0, 0, 0, 1, 0, "R8 readback");

        // R4/R5 thresholds 8,16,32
        for (int t = 1; t < 4; t++) begin
            trig_lvl_i = 2'(t);
            for (int i = 0; i < thr(2'(t)); i++) step(1, 8'(i + 16 * t), 2'd3, 0, 0, "R4 fill");
            step(0, 0, 0, 1, 0, "R5 drop below");
            while (q.size() > 0) step(0, 0, 0, 1, 0, "R5 drain");
        end

        // R6/R9 full queue
        trig_lvl_i = 2'd1;
        for (int i = 0; i < 64; i++) step(1, 8'(i * 3), 2'd3, 0, 0, "R6 fill");
        step(1, 8'hEE, 2'd3, 0, 0, "R6 drop");
        step(1, 8'h77, 2'd3, 1, 0, "R9 full push+pop");
        step(0, 0, 0, 0, 1, "R7 ack");
        for (int i = 0; i < 56; i++) step(0, 0, 0, 1, 0, "R2 drain");
        step(1, 8'h31, 2'd3, 1, 0, "R9 push+pop");
        while (q.size() > 0) step(0, 0, 0, 1, 0, "R9 drain");
        // R7 set wins over ack
        for (int i = 0; i < 64; i++) step(1, 8'(i), 2'd3, 0, 0, "R7 fill");
        step(1, 8'h11, 2'd3, 0, 1, "R7 set beats ack");
        step(0, 0, 0, 0, 0, "R7 sticky");
        step(0, 0, 0, 0, 1, "R7 clear");

        // R10/R11 single-register mode
        set_mode(0);
        step(1, 8'h41, 2'd3, 0, 0, "R10 hold");
        step(1, 8'hF2, 2'd0, 0, 0, "R10 overwrite");
        step(0, 0, 0, 1, 0, "R10 read");
        step(0, 0, 0, 0, 1, "R10 ack");
        step(1, 8'h33, 2'd3, 0, 0, "R10 hold2");
        step(1, 8'h44, 2'd3, 1, 0, "R10 read+new");
        step(0, 0, 0, 1, 0, "R10 read new");
        step(1, 8'h55, 2'd3, 0, 0, "R11 pre");
        set_mode(1);
        step(0, 0, 0, 1, 0, "R11 empty after");

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule